// File: doc/BRIEF.md
# CAN Controller Freeze Sequencer

This block decides when a CAN protocol controller may stop and hold still for configuration or debugging. A freeze request comes from a software halt bit or from the chip's debug state, and either one counts only when a separate freeze-enable bit is set. The sequencer grants the freeze only at a point where stopping is safe: the bus engine must report a safe protocol phase, and every message-buffer move engine must be idle.

Once frozen, the block does four things:

- It stops the bit-time prescaler.
- It forces the transmit line recessive.
- It tells the receiver to ignore the bus.
- It opens the error counters for writes.

It also raises the not-ready and acknowledge status bits. When the request goes away, it undoes all of this. Protocol activity is released only after the prescaler has run for one full clock.

The sequencer has three states: run, waiting for a safe point, and frozen. All status and control outputs come from a single registered stage that follows the frozen state. The reset input is asynchronous on assertion. Its release passes through a two-stage synchronizer.

Top module: `can_freeze_seq`

## Requirements
- R1: A freeze is requested exactly when `freeze_en` is 1 and at least one of `halt_req` or `debug_mode` is 1. With `freeze_en` at 0, neither source produces an acknowledge.
- R2: Entry waits for a safe protocol phase. `proto_state` is encoded as 0 idle, 1 frame in progress, 2 intermission, 3 error passive, 4 bus off. Codes 1, 5, 6 and 7 are unsafe and block entry.
- R3: Entry also waits until every bit of `move_busy` is 0. Any single busy flag blocks entry.
- R4: The safe-phase and idle-mover conditions must hold together in one cycle to enter the frozen state. `freeze_ack` and `not_ready` rise one clock after that entry. From a fresh request with both conditions already true, they rise at the third rising edge and are still 0 after the second.
- R5: While `freeze_ack` is 1, `presc_en` is 0, `tx_recessive` is 1 and `rx_ignore` is 1. The frozen state holds even if the protocol phase or the busy flags change.
- R6: `ecr_wr_en` is 1 only while frozen, and 0 in every other state.
- R7: Freeze is left when the request drops, that is when `freeze_en` clears or when both `halt_req` and `debug_mode` are 0. All frozen outputs return to normal at the second rising edge after the drop.
- R8: `bit_engine_go` is 1 only when `presc_en` is 1 and has already been 1 at the previous edge. After an exit it rises one edge after `presc_en`.
- R9: If the request drops while waiting for a safe point, the sequencer returns to run without ever raising `freeze_ack`.
- R10: While `rst_n` is 0, `presc_en` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| halt_req | input | 1 | Software halt request |
| freeze_en | input | 1 | Freeze enable; gates both request sources |
| debug_mode | input | 1 | Chip debug state |
| proto_state | input | 3 | Protocol phase of the bus engine (encoding in R2) |
| move_busy | input | N_MOVERS (2) | Busy flags of the buffer move engines |
| presc_en | output | 1 | Bit-time prescaler enable |
| tx_recessive | output | 1 | Forces TX to recessive |
| rx_ignore | output | 1 | Receiver ignores the bus |
| ecr_wr_en | output | 1 | Error counter write enable |
| not_ready | output | 1 | Not-ready status bit |
| freeze_ack | output | 1 | Freeze acknowledge status bit |
| bit_engine_go | output | 1 | Protocol activity permitted |

## Verification
A fresh request whose conditions are already met moves the sequencer to waiting at the first rising edge and to frozen at the second. The frozen outputs appear at the third edge, so each table vector is sampled at the falling edge after its third rising edge. The latency check also samples after the second edge and expects 0 there. A request that is released is undone at the second edge, and `bit_engine_go` follows at the third, so the release checks sample at those two points. When a request is already waiting and the last blocker clears, the acknowledge is due two edges later. The abort test samples on every cycle to confirm the acknowledge never rises.

// File: rtl/fz_pkg.sv
`timescale 1ns/1ps
package fz_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    BP_IDLE      = 3'd0,
    BP_FRAME     = 3'd1,
    BP_INTERMIS  = 3'd2,
    BP_ERR_PASS  = 3'd3,
    BP_BUS_OFF   = 3'd4
  } bus_phase_e;

  typedef enum logic [1:0] {
    SQ_RUN    = 2'd0,
    SQ_WAIT   = 2'd1,
    SQ_FROZEN = 2'd2
  } seq_state_e;

endpackage

// File: rtl/fz_rst_sync.sv
`timescale 1ns/1ps
module fz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fz_req_decode.sv
`timescale 1ns/1ps
module fz_req_decode (
  input  logic halt_req,
  input  logic freeze_en,
  input  logic debug_mode,
  output logic req
);

  // Either source asks for a freeze; the enable gates both (R1).
  always_comb begin
    req = freeze_en & (halt_req | debug_mode);
  end

endmodule

// File: rtl/fz_safe_detect.sv
`timescale 1ns/1ps
module fz_safe_detect
  import fz_pkg::*;
#(
  parameter int N_MOVERS = 2
) (
  input  logic [PHASE_W-1:0]  proto_state,
  input  logic [N_MOVERS-1:0] move_busy,
  output logic                safe_ok
);

  logic phase_safe;
  logic [N_MOVERS:0] idle_chain;

  // R2: only quiet protocol phases allow a stop.
  always_comb begin
    case (proto_state)
      BP_IDLE, BP_INTERMIS, BP_ERR_PASS, BP_BUS_OFF: phase_safe = 1'b1;
      default:                                       phase_safe = 1'b0;
    endcase
  end

  // R3: every mover must be idle; built as a ripple AND across the engines.
  assign idle_chain[0] = 1'b1;
  for (genvar g = 0; g < N_MOVERS; g++) begin : g_mover
    assign idle_chain[g+1] = idle_chain[g] & ~move_busy[g];
  end

  assign safe_ok = phase_safe & idle_chain[N_MOVERS];

endmodule

// File: rtl/fz_fsm.sv
`timescale 1ns/1ps
module fz_fsm
  import fz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic safe_ok,
  output logic frozen_q,
  output logic bit_go
);

  seq_state_e state_q, state_d;
  logic       state_en;
  logic       in_frozen;
  logic       run_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_RUN:    if (req) state_d = SQ_WAIT;
      SQ_WAIT:   if (!req) state_d = SQ_RUN;
                 else if (safe_ok) state_d = SQ_FROZEN;
      SQ_FROZEN: if (!req) state_d = SQ_RUN;
      default:   state_d = SQ_RUN;
    endcase
  end

  assign state_en  = (state_d != state_q);
  assign in_frozen = (state_q == SQ_FROZEN);

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SQ_RUN;
    else if (state_en) state_q <= state_d;
  end

  // Output stage: one cycle behind the state (R4, R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     frozen_q <= 1'b0;
    else if (frozen_q != in_frozen) frozen_q <= in_frozen;
  end

  // Prescaler-running history for the protocol release (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_q <= 1'b0;
    else if (run_q != ~frozen_q)    run_q <= ~frozen_q;
  end

  assign bit_go = ~frozen_q & run_q;

  // Frozen is entered only from a cycle with request and safe conditions together
  assert_entry_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frozen) |-> $past(req && safe_ok));

  // Acknowledge stage follows entry by one clock
  assert_ack_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frozen) |=> frozen_q);

  // Acknowledge is never raised after two cycles without a request
  assert_no_ack_unrequested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && $past(!req)) |=> !frozen_q);

  // Protocol release needs the prescaler to have run the cycle before
  assert_go_after_presc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen_q) |-> !bit_go);

  // Leaving the frozen state clears the output stage on the next edge
  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frozen) |=> !frozen_q);

endmodule

// File: rtl/can_freeze_seq.sv
`timescale 1ns/1ps
module can_freeze_seq
  import fz_pkg::*;
#(
  parameter int N_MOVERS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                freeze_en,
  input  logic                debug_mode,
  input  logic [PHASE_W-1:0]  proto_state,
  input  logic [N_MOVERS-1:0] move_busy,
  output logic                presc_en,
  output logic                tx_recessive,
  output logic                rx_ignore,
  output logic                ecr_wr_en,
  output logic                not_ready,
  output logic                freeze_ack,
  output logic                bit_engine_go
);

  logic rst_n_int;
  logic req;
  logic safe_ok;
  logic frozen_q;
  logic bit_go;

  fz_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  fz_req_decode u_req (
    .halt_req   (halt_req),
    .freeze_en  (freeze_en),
    .debug_mode (debug_mode),
    .req        (req)
  );

  fz_safe_detect #(.N_MOVERS(N_MOVERS)) u_safe (
    .proto_state (proto_state),
    .move_busy   (move_busy),
    .safe_ok     (safe_ok)
  );

  fz_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req      (req),
    .safe_ok  (safe_ok),
    .frozen_q (frozen_q),
    .bit_go   (bit_go)
  );

  // Frozen-state controls (R5, R6)
  assign presc_en      = ~frozen_q;
  assign tx_recessive  = frozen_q;
  assign rx_ignore     = frozen_q;
  assign ecr_wr_en     = frozen_q;
  assign not_ready     = frozen_q;
  assign freeze_ack    = frozen_q;
  assign bit_engine_go = bit_go;

  // Error counters open only while the acknowledge is high
  assert_ecr_only_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    ecr_wr_en |-> (freeze_ack && !bit_engine_go));

  // A frozen controller keeps the line quiet and the prescaler stopped
  assert_frozen_pins_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    freeze_ack |-> (!presc_en && tx_recessive && rx_ignore));

endmodule

// File: tb/can_freeze_seq_test.sv
`timescale 1ns/1ps
module can_freeze_seq_test;

  logic       clk;
  logic       rst_n;
  logic       halt_req, freeze_en, debug_mode;
  logic [2:0] proto_state;
  logic [1:0] move_busy;
  logic presc_en, tx_recessive, rx_ignore, ecr_wr_en, not_ready, freeze_ack, bit_engine_go;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  can_freeze_seq #(.N_MOVERS(2)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .freeze_en(freeze_en),
    .debug_mode(debug_mode), .proto_state(proto_state), .move_busy(move_busy),
    .presc_en(presc_en), .tx_recessive(tx_recessive), .rx_ignore(rx_ignore),
    .ecr_wr_en(ecr_wr_en), .not_ready(not_ready), .freeze_ack(freeze_ack),
    .bit_engine_go(bit_engine_go)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {halt, en, dbg, phase[2:0], busy[1:0], expected freeze}
  localparam logic [8:0] VEC [12] = '{
    {1'b1,1'b1,1'b0,3'd0,2'b00,1'b1},  // R1 halt source, idle
    {1'b0,1'b1,1'b1,3'd2,2'b00,1'b1},  // R1/R2 debug source, intermission
    {1'b1,1'b0,1'b0,3'd0,2'b00,1'b0},  // R1 halt without enable
    {1'b0,1'b0,1'b1,3'd0,2'b00,1'b0},  // R1 debug without enable
    {1'b1,1'b1,1'b0,3'd1,2'b00,1'b0},  // R2 frame in progress
    {1'b1,1'b1,1'b0,3'd3,2'b00,1'b1},  // R2 error passive
    {1'b1,1'b1,1'b0,3'd4,2'b00,1'b1},  // R2 bus off
    {1'b1,1'b1,1'b0,3'd5,2'b00,1'b0},  // R2 reserved code
    {1'b1,1'b1,1'b0,3'd0,2'b01,1'b0},  // R3 mover 0 busy
    {1'b1,1'b1,1'b0,3'd0,2'b10,1'b0},  // R3 mover 1 busy
    {1'b1,1'b1,1'b1,3'd0,2'b00,1'b1},  // R1 both sources
    {1'b0,1'b1,1'b0,3'd0,2'b00,1'b0}   // R1 enable alone
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    halt_req = 0; freeze_en = 0; debug_mode = 0; proto_state = 3'd0; move_busy = 2'b00;
  endtask

  task automatic frozen_set(input string tag, input logic f);
    check({tag, " ack"}, freeze_ack, f);
    check({tag, " not_ready"}, not_ready, f);
    check({tag, " presc_en"}, presc_en, ~f);
    check({tag, " tx_recessive"}, tx_recessive, f);
    check({tag, " rx_ignore"}, rx_ignore, f);
    check({tag, " ecr_wr_en"}, ecr_wr_en, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    edges(3);
    // R10 reset state
    frozen_set("R10 reset", 1'b0);
    check("R10 reset bit_engine_go", bit_engine_go, 1'b0);
    rst_n = 1;
    edges(6);
    check("R8 go after reset release", bit_engine_go, 1'b1);

    for (int i = 0; i < 12; i++) begin
      {halt_req, freeze_en, debug_mode, proto_state, move_busy} = VEC[i][8:1];
      edges(3);
      frozen_set($sformatf("R5 vec%0d", i), VEC[i][0]);
      check($sformatf("R6 vec%0d go", i), bit_engine_go, ~VEC[i][0]);
      quiet();
      edges(2);
      frozen_set($sformatf("R7 vec%0d release", i), 1'b0);
      edges(1);
      check($sformatf("R8 vec%0d go", i), bit_engine_go, 1'b1);
    end

    // R4 exact latency: not yet at the second edge, present at the third
    halt_req = 1; freeze_en = 1;
    edges(2);
    check("R4 ack not before third edge", freeze_ack, 1'b0);
    edges(1);
    check("R4 ack at third edge", freeze_ack, 1'b1);
    check("R4 not_ready at third edge", not_ready, 1'b1);
    // R5 frozen state holds while bus inputs move
    proto_state = 3'd1; move_busy = 2'b11;
    edges(3);
    frozen_set("R5 hold", 1'b1);
    // R7/R8 exit by clearing both sources, enable left set
    halt_req = 0; proto_state = 3'd0; move_busy = 2'b00;
    edges(1);
    check("R7 still frozen after one edge", freeze_ack, 1'b1);
    edges(1);
    frozen_set("R7 exit", 1'b0);
    check("R8 go lags presc_en", bit_engine_go, 1'b0);
    edges(1);
    check("R8 go one edge later", bit_engine_go, 1'b1);
    edges(2);

    // R3 drain: waiting, phase safe but mover busy, then mover clears
    halt_req = 1; freeze_en = 1; proto_state = 3'd1; move_busy = 2'b01;
    edges(4);
    proto_state = 3'd2;
    edges(3);
    check("R3 blocked by busy mover", freeze_ack, 1'b0);
    move_busy = 2'b00;
    edges(1);
    check("R4 one edge after drain", freeze_ack, 1'b0);
    edges(1);
    check("R4 two edges after drain", freeze_ack, 1'b1);
    quiet();
    edges(4);

    // R9 abort from waiting: request drops as the phase turns safe
    debug_mode = 1; freeze_en = 1; proto_state = 3'd1;
    edges(2);
    quiet();
    for (int c = 0; c < 5; c++) begin
      edges(1);
      check($sformatf("R9 abort cycle %0d", c), freeze_ack, 1'b0);
      check($sformatf("R9 abort presc cycle %0d", c), presc_en, 1'b1);
    end

    // R1 freeze_en clear exits even with halt held
    halt_req = 1; freeze_en = 1;
    edges(3);
    check("R1 frozen before enable clear", freeze_ack, 1'b1);
    freeze_en = 0;
    edges(2);
    check("R7 enable clear exits", freeze_ack, 1'b0);
    quiet();
    edges(2);

    // R10 reset in the middle of a freeze
    halt_req = 1; freeze_en = 1;
    edges(3);
    rst_n = 0;
    #1;
    frozen_set("R10 async reset", 1'b0);
    edges(2);
    rst_n = 1;
    quiet();
    edges(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule